// File: doc/BRIEF.md
# Clock-Synchronous Serial Port with Flow Control

This block is a full-duplex, eight-bit serial port that moves one byte out and one byte in per frame, with a shared serial clock. A host loads a byte through a write strobe into a one-byte transmit holding register. The frame engine takes the byte from there into its shift stage and sends it least significant bit first. In the same frame it assembles the incoming byte and hands it to a one-byte receive holding register. Every frame, including a frame meant only to receive, starts from a byte written to the transmit holding register. To receive only, the host writes a dummy byte.

The port has two clock modes. In internal-clock mode the port drives the serial clock from a programmable divider. A peer-busy input can then hold off the start of any new frame. In external-clock mode the serial clock comes in on a pin, is synchronized and edge-detected. A local-busy output then tells the remote master to wait until the host has read the received byte. Sticky interrupt requests for transmit and receive are cleared by explicit acknowledge inputs.

Top module: `sync_serial_port`

## Requirements
- R1: In internal-clock mode with `div_val` = n, each low and each high phase of `sclk_out` lasts n+1 system clock cycles, so the full period is 2(n+1). `sclk_oe` is 1 in this mode and 0 in external-clock mode.
- R2: A frame carries exactly 8 bits, least significant bit first, on both `sdo` and `sdi`. The serial clock gives exactly 8 rising edges per frame.
- R3: The serial clock idles high. `sdo` changes only on a falling edge of the serial clock, and `sdi` is sampled on a rising edge. `sdo` is 1 after reset.
- R4: A write on `tb_wr` clears `tb_empty`. When the byte moves into the frame engine, `tb_empty` returns to 1. If `irq_on_done` = 0, `tx_irq` is raised at that moment.
- R5: `tx_idle` is 0 while a frame is shifting or a byte is pending, and 1 otherwise. If `irq_on_done` = 1, `tx_irq` is raised at the end of a frame and not at the handoff.
- R6: In internal-clock mode with `flow_en` = 1, no frame starts while `peer_busy` = 1. Clearing `tx_en` lets the current frame finish but starts no further frame.
- R7: When a frame ends with `rx_en` = 1 and `rb_full` = 0, the received byte appears on `rb_rdata`, and both `rb_full` and `rx_irq` become 1. A pulse on `rb_rd` clears `rb_full`.
- R8: In external-clock mode with `flow_en` = 1, `local_busy` is 0 while reception is enabled and ready. It goes to 1 when a frame is received and stays 1 until an `rb_rd` pulse clears `rb_full`. It is 1 whenever `rx_en` = 0.
- R9: In external-clock mode the frame is clocked by `sclk_in` (idling high), after `tx_en` = 1 and a byte written to the transmit buffer. That byte is sent on `sdo` while the incoming byte is received.
- R10: `tx_irq` and `rx_irq` stay at 1 until a pulse on `tx_irq_ack` or `rx_irq_ack` respectively.
- R11: If a frame ends with `rx_en` = 1 while `rb_full` = 1, `overrun` becomes 1 and `rb_rdata` keeps its old value. An `rb_rd` pulse clears `overrun`.
- R12: A frame that ends with `rx_en` = 0 changes neither `rb_rdata`, `rb_full` nor `rx_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_ext | input | 1 | 1 = serial clock from `sclk_in`, 0 = internal divider |
| flow_en | input | 1 | Enables peer-busy gating and the local-busy output |
| tx_en | input | 1 | Allows new frames to start |
| rx_en | input | 1 | Allows received bytes into the receive buffer |
| irq_on_done | input | 1 | 0 = `tx_irq` on buffer handoff, 1 = `tx_irq` on frame end |
| div_val | input | DIV_W | Half-period divider value n |
| tb_wr | input | 1 | Write strobe for the transmit buffer |
| tb_wdata | input | DATA_W | Byte to transmit |
| rb_rd | input | 1 | Read strobe for the receive buffer |
| rb_rdata | output | DATA_W | Receive buffer contents |
| tb_empty | output | 1 | Transmit buffer empty |
| tx_idle | output | 1 | No frame shifting and no byte pending |
| rb_full | output | 1 | Receive buffer holds an unread byte |
| overrun | output | 1 | A byte was lost because the buffer was full |
| tx_irq | output | 1 | Sticky transmit interrupt request |
| rx_irq | output | 1 | Sticky receive interrupt request |
| tx_irq_ack | input | 1 | Clears `tx_irq` |
| rx_irq_ack | input | 1 | Clears `rx_irq` |
| sclk_in | input | 1 | External serial clock |
| sclk_out | output | 1 | Internally generated serial clock |
| sclk_oe | output | 1 | Output enable for `sclk_out` |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| peer_busy | input | 1 | Peer not ready, holds off frames (internal mode) |
| local_busy | output | 1 | Port not ready to receive (external mode) |

## Verification
A wrong bit index or frame state in the engine shows at the ports within one frame. The looped-back byte in `rb_rdata` would differ from the byte written, or the count of serial clock rising edges would not be eight. Divider faults show at once as a wrong low-phase length on `sclk_out`. A bad handoff or flag update shows within a cycle or two as a wrong `tb_empty`, `rb_full`, `overrun` or interrupt level. A lost local-busy state shows as `local_busy` dropping before the receive buffer is read.

// File: rtl/ssp_pkg.sv
`timescale 1ns/1ps
package ssp_pkg;
  typedef enum logic [0:0] {
    ENG_IDLE  = 1'b0,
    ENG_SHIFT = 1'b1
  } eng_state_t;
endpackage

// File: rtl/ssp_baud_gen.sv
`timescale 1ns/1ps
// Half-period tick generator: one tick every div_val+1 cycles while run is high.
module ssp_baud_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = run && (cnt_q == div_val);
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R1: the counter restarts from zero whenever the engine is not running
  p_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));
endmodule

// File: rtl/ssp_edge_sync.sv
`timescale 1ns/1ps
// Synchronizer chain for the external serial clock with edge detection.
module ssp_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              lvl;

  assign lvl  = sync_q[STAGES-1];
  assign rise = lvl && !prev_q;
  assign fall = !lvl && prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_in};
      prev_q <= lvl;
    end
  end

  // R9: two detected edges of the same kind never come back to back
  p_single_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
  p_single_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/ssp_frame_eng.sv
`timescale 1ns/1ps
// Frame engine: loads a byte, drives the serial clock, shifts data both ways.
module ssp_frame_eng
  import ssp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_mode,
  input  logic              start_req,
  input  logic [DATA_W-1:0] tb_data,
  input  logic              tick,
  input  logic              ext_rise,
  input  logic              ext_fall,
  input  logic              sdi,
  output logic              load,
  output logic              done,
  output logic [DATA_W-1:0] rx_word,
  output logic              sdo,
  output logic              sclk_int,
  output logic              busy,
  output logic              baud_run
);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  eng_state_t        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] tx_sr_q, tx_sr_d;
  logic [DATA_W-1:0] rx_sr_q, rx_sr_d;
  logic              sdo_q, sdo_d;
  logic              sclk_q, sclk_d;
  logic              fall_ev, rise_ev;

  assign fall_ev  = ext_mode ? ext_fall : (tick && sclk_q);
  assign rise_ev  = ext_mode ? ext_rise : (tick && !sclk_q);
  assign busy     = (state_q == ENG_SHIFT);
  assign baud_run = busy && !ext_mode;
  assign sdo      = sdo_q;
  assign sclk_int = sclk_q;
  assign rx_word  = rx_sr_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    tx_sr_d = tx_sr_q;
    rx_sr_d = rx_sr_q;
    sdo_d   = sdo_q;
    sclk_d  = sclk_q;
    load    = 1'b0;
    done    = 1'b0;
    unique case (state_q)
      ENG_IDLE: begin
        sclk_d = 1'b1;
        if (start_req) begin
          load    = 1'b1;
          tx_sr_d = tb_data;
          idx_d   = '0;
          state_d = ENG_SHIFT;
        end
      end
      ENG_SHIFT: begin
        if (fall_ev) begin
          sdo_d = tx_sr_q[idx_q];
          if (!ext_mode) sclk_d = 1'b0;
        end else if (rise_ev) begin
          rx_sr_d[idx_q] = sdi;
          if (!ext_mode) sclk_d = 1'b1;
          if (idx_q == LAST_IDX) begin
            done    = 1'b1;
            idx_d   = '0;
            state_d = ENG_IDLE;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      default: state_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      idx_q   <= '0;
      tx_sr_q <= '0;
      rx_sr_q <= '0;
      sdo_q   <= 1'b1;
      sclk_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      tx_sr_q <= tx_sr_d;
      rx_sr_q <= rx_sr_d;
      sdo_q   <= sdo_d;
      sclk_q  <= sclk_d;
    end
  end

  // R3: data out moves only on a serial-clock falling edge
  p_sdo_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_ev |=> $stable(sdo));
  // R3: the internal serial clock is high whenever no frame is shifting
  p_idle_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !ext_mode |-> sclk_int);
  // R2: a frame ends only with the final bit index
  p_done_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (idx_q == LAST_IDX));
endmodule

// File: rtl/sync_serial_port.sv
`timescale 1ns/1ps
// Top: holding registers, flags, interrupts and flow control around the engine.
module sync_serial_port #(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_ext,
  input  logic              flow_en,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic              irq_on_done,
  input  logic [DIV_W-1:0]  div_val,
  input  logic              tb_wr,
  input  logic [DATA_W-1:0] tb_wdata,
  input  logic              rb_rd,
  output logic [DATA_W-1:0] rb_rdata,
  output logic              tb_empty,
  output logic              tx_idle,
  output logic              rb_full,
  output logic              overrun,
  output logic              tx_irq,
  output logic              rx_irq,
  input  logic              tx_irq_ack,
  input  logic              rx_irq_ack,
  input  logic              sclk_in,
  output logic              sclk_out,
  output logic              sclk_oe,
  output logic              sdo,
  input  logic              sdi,
  input  logic              peer_busy,
  output logic              local_busy
);
  logic [DATA_W-1:0] tb_q, tb_d, rb_q, rb_d;
  logic              tbe_q, tbe_d, rbf_q, rbf_d, ovr_q, ovr_d;
  logic              txi_q, txi_d, rxi_q, rxi_d, lbusy_q, lbusy_d;
  logic              start_req, load, done, busy, baud_run, tick;
  logic              ext_rise, ext_fall, sclk_int;
  logic [DATA_W-1:0] rx_word;
  logic              capture, ovr_hit, peer_hold;

  ssp_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(baud_run), .div_val(div_val), .tick(tick));

  ssp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(sclk_in), .rise(ext_rise), .fall(ext_fall));

  ssp_frame_eng #(.DATA_W(DATA_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .ext_mode(mode_ext), .start_req(start_req),
    .tb_data(tb_q), .tick(tick), .ext_rise(ext_rise), .ext_fall(ext_fall),
    .sdi(sdi), .load(load), .done(done), .rx_word(rx_word), .sdo(sdo),
    .sclk_int(sclk_int), .busy(busy), .baud_run(baud_run));

  assign peer_hold  = !mode_ext && flow_en && peer_busy;
  assign start_req  = tx_en && !tbe_q && !peer_hold;
  assign capture    = done && rx_en && !rbf_q;
  assign ovr_hit    = done && rx_en && rbf_q;

  assign rb_rdata   = rb_q;
  assign tb_empty   = tbe_q;
  assign rb_full    = rbf_q;
  assign overrun    = ovr_q;
  assign tx_irq     = txi_q;
  assign rx_irq     = rxi_q;
  assign tx_idle    = !busy && tbe_q;
  assign sclk_out   = mode_ext ? 1'b1 : sclk_int;
  assign sclk_oe    = !mode_ext;
  assign local_busy = flow_en && mode_ext && (lbusy_q || !rx_en);

  always_comb begin
    tb_d    = tb_wr ? tb_wdata : tb_q;
    tbe_d   = tbe_q;
    if (tb_wr)     tbe_d = 1'b0;
    else if (load) tbe_d = 1'b1;

    rb_d    = capture ? rx_word : rb_q;
    rbf_d   = rbf_q;
    if (capture)    rbf_d = 1'b1;
    else if (rb_rd) rbf_d = 1'b0;

    ovr_d   = ovr_q;
    if (ovr_hit)             ovr_d = 1'b1;
    else if (rb_rd && rbf_q) ovr_d = 1'b0;

    txi_d   = txi_q;
    if ((load && !irq_on_done) || (done && irq_on_done)) txi_d = 1'b1;
    else if (tx_irq_ack)                                 txi_d = 1'b0;

    rxi_d   = rxi_q;
    if (capture)         rxi_d = 1'b1;
    else if (rx_irq_ack) rxi_d = 1'b0;

    lbusy_d = lbusy_q;
    if (done && rx_en)       lbusy_d = 1'b1;
    else if (rb_rd && rbf_q) lbusy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tb_q    <= '0;
      rb_q    <= '0;
      tbe_q   <= 1'b1;
      rbf_q   <= 1'b0;
      ovr_q   <= 1'b0;
      txi_q   <= 1'b0;
      rxi_q   <= 1'b0;
      lbusy_q <= 1'b0;
    end else begin
      tb_q    <= tb_d;
      rb_q    <= rb_d;
      tbe_q   <= tbe_d;
      rbf_q   <= rbf_d;
      ovr_q   <= ovr_d;
      txi_q   <= txi_d;
      rxi_q   <= rxi_d;
      lbusy_q <= lbusy_d;
    end
  end

  // R4: handoff without a concurrent write leaves the buffer empty
  p_handoff_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load && !tb_wr |=> tb_empty);
  // R7: a completed frame into an empty buffer fills it and requests service
  p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done && rx_en && !rb_full |=> rb_full && rx_irq);
  // R11: a frame into a full buffer flags overrun and keeps the old byte
  p_overrun_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done && rx_en && rb_full |=> overrun && $stable(rb_rdata));
  // R6: no frame starts while the peer signals busy
  p_peer_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !mode_ext && flow_en && peer_busy |=> !busy);
  // R10: interrupt requests persist until acknowledged
  p_irq_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq && !tx_irq_ack |=> tx_irq);
  // R8: local busy holds while an unread byte remains
  p_busy_until_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    local_busy && rb_full && !rb_rd |=> local_busy || !(flow_en && mode_ext));
endmodule

// File: tb/tb_sync_serial_port.sv
`timescale 1ns/1ps
module tb_sync_serial_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_ext = 1'b0, flow_en = 1'b0, tx_en = 1'b1, rx_en = 1'b1;
  logic       irq_on_done = 1'b0;
  logic [7:0] div_val = 8'd1;
  logic       tb_wr = 1'b0, rb_rd = 1'b0;
  logic [7:0] tb_wdata = 8'h00;
  logic [7:0] rb_rdata;
  logic       tb_empty, tx_idle, rb_full, overrun, tx_irq, rx_irq;
  logic       tx_irq_ack = 1'b0, rx_irq_ack = 1'b0;
  logic       sclk_in = 1'b1, sclk_out, sclk_oe, sdo, sdi, ext_sdi = 1'b1;
  logic       loop_en = 1'b1, peer_busy = 1'b0, local_busy;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;
  assign sdi = loop_en ? sdo : ext_sdi;

  sync_serial_port dut (
    .clk(clk), .rst_n(rst_n), .mode_ext(mode_ext), .flow_en(flow_en),
    .tx_en(tx_en), .rx_en(rx_en), .irq_on_done(irq_on_done), .div_val(div_val),
    .tb_wr(tb_wr), .tb_wdata(tb_wdata), .rb_rd(rb_rd), .rb_rdata(rb_rdata),
    .tb_empty(tb_empty), .tx_idle(tx_idle), .rb_full(rb_full), .overrun(overrun),
    .tx_irq(tx_irq), .rx_irq(rx_irq), .tx_irq_ack(tx_irq_ack), .rx_irq_ack(rx_irq_ack),
    .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sdo(sdo), .sdi(sdi),
    .peer_busy(peer_busy), .local_busy(local_busy));

  // Serial-line monitor for internal-clock mode
  int         m_rise = 0, m_low = 0, m_last_low = 0, m_viol = 0;
  logic [7:0] m_cap = 8'h00;
  logic       m_prev = 1'b1, m_prev_sdo = 1'b1;
  always @(negedge clk) begin
    if (rst_n && !mode_ext) begin
      if (sclk_out && !m_prev) begin
        m_rise = m_rise + 1;
        m_cap = {sdo, m_cap[7:1]};
        m_last_low = m_low;
      end
      if (!sclk_out) m_low = m_prev ? 1 : m_low + 1;
      if (sclk_out && m_prev && (sdo !== m_prev_sdo)) m_viol = m_viol + 1;
    end
    m_prev = sclk_out;
    m_prev_sdo = sdo;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_tb(input logic [7:0] v);
    @(negedge clk); tb_wr = 1'b1; tb_wdata = v;
    @(negedge clk); tb_wr = 1'b0;
  endtask

  task automatic read_rb();
    @(negedge clk); rb_rd = 1'b1;
    @(negedge clk); rb_rd = 1'b0;
  endtask

  task automatic ack_all();
    @(negedge clk); tx_irq_ack = 1'b1; rx_irq_ack = 1'b1;
    @(negedge clk); tx_irq_ack = 1'b0; rx_irq_ack = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (tx_idle) break;
    end
    cycles(2);
  endtask

  task automatic t_reset();
    chk("R4 tb_empty after reset", tb_empty, 1);
    chk("R5 tx_idle after reset", tx_idle, 1);
    chk("R7 rb_full after reset", rb_full, 0);
    chk("R10 irqs after reset", {tx_irq, rx_irq}, 0);
    chk("R3 idle clock and data high", {sclk_out, sdo}, 2'b11);
    chk("R1 clock output enabled", sclk_oe, 1);
  endtask

  task automatic t_loop(input logic [7:0] dv, input logic [7:0] v);
    int base;
    div_val = dv;
    base = m_rise;
    @(negedge clk); tb_wr = 1'b1; tb_wdata = v;
    @(negedge clk); tb_wr = 1'b0;
    chk("R4 write clears tb_empty", tb_empty, 0);
    wait_idle();
    chk("R2 eight rising edges", m_rise - base, 8);
    chk("R2 lsb-first line byte", m_cap, v);
    chk("R1 low phase length", m_last_low, dv + 1);
    chk("R7 looped byte in buffer", rb_rdata, v);
    chk("R7 rb_full and rx_irq", {rb_full, rx_irq}, 2'b11);
    chk("R4 handoff irq", tx_irq, 1);
    chk("R3 sdo stable while clock high", m_viol, 0);
    cycles(5);
    chk("R10 irqs held without ack", {tx_irq, rx_irq}, 2'b11);
    ack_all();
    chk("R10 irqs cleared by ack", {tx_irq, rx_irq}, 2'b00);
    read_rb();
    chk("R7 read clears rb_full", rb_full, 0);
  endtask

  task automatic t_peer_gate();
    int base;
    div_val = 8'd1; flow_en = 1'b1; peer_busy = 1'b1;
    base = m_rise;
    write_tb(8'h5A);
    cycles(60);
    chk("R6 no clock while peer busy", m_rise - base, 0);
    chk("R6 byte still pending", {tb_empty, tx_idle}, 2'b00);
    peer_busy = 1'b0;
    wait_idle();
    chk("R6 frame after release", m_cap, 8'h5A);
    chk("R6 edges after release", m_rise - base, 8);
    flow_en = 1'b0;
    read_rb(); ack_all();
  endtask

  task automatic t_txen_overrun();
    int base;
    div_val = 8'd2;
    base = m_rise;
    write_tb(8'h11);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (tb_empty) break;
    end
    write_tb(8'h22);
    tx_en = 1'b0;
    cycles(200);
    chk("R6 only current frame after tx_en clear", m_rise - base, 8);
    chk("R6 second byte waits", {tb_empty, tx_idle}, 2'b00);
    chk("R7 first byte captured", rb_rdata, 8'h11);
    tx_en = 1'b1;
    wait_idle();
    chk("R2 second frame byte", m_cap, 8'h22);
    chk("R11 overrun set", overrun, 1);
    chk("R11 buffer keeps old byte", rb_rdata, 8'h11);
    read_rb();
    chk("R11 read clears overrun and full", {overrun, rb_full}, 2'b00);
    ack_all();
  endtask

  task automatic t_done_irq();
    irq_on_done = 1'b1; div_val = 8'd1;
    write_tb(8'hE7);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (tb_empty) break;
    end
    chk("R5 no irq at handoff in done mode", tx_irq, 0);
    chk("R5 tx_idle low while shifting", tx_idle, 0);
    wait_idle();
    chk("R5 irq at frame end", tx_irq, 1);
    irq_on_done = 1'b0;
    read_rb(); ack_all();
  endtask

  task automatic t_rx_off();
    rx_en = 1'b0;
    write_tb(8'h77);
    wait_idle();
    chk("R12 buffer unchanged", rb_rdata, 8'hE7);
    chk("R12 no full, no irq", {rb_full, rx_irq}, 2'b00);
    rx_en = 1'b1;
  endtask

  task automatic t_ext();
    logic [7:0] got = 8'h00;
    logic [7:0] rxv = 8'hC3;
    mode_ext = 1'b1; flow_en = 1'b1; loop_en = 1'b0;
    cycles(2);
    chk("R1 clock output disabled in external mode", sclk_oe, 0);
    chk("R8 local_busy low when ready", local_busy, 0);
    write_tb(8'h96);
    cycles(4);
    for (int b = 0; b < 8; b++) begin
      sclk_in = 1'b0; ext_sdi = rxv[b];
      cycles(8);
      got = {sdo, got[7:1]};
      sclk_in = 1'b1;
      cycles(8);
    end
    cycles(4);
    chk("R9 dummy byte sent on sdo", got, 8'h96);
    chk("R9 external byte received", rb_rdata, 8'hC3);
    chk("R8 local_busy after reception", local_busy, 1);
    cycles(20);
    chk("R8 local_busy held until read", local_busy, 1);
    read_rb();
    chk("R8 local_busy released by read", local_busy, 0);
    rx_en = 1'b0;
    cycles(1);
    chk("R8 local_busy with rx disabled", local_busy, 1);
    rx_en = 1'b1;
  endtask

  initial begin
    cycles(3);
    rst_n = 1'b1;
    cycles(2);
    t_reset();
    t_loop(8'd1, 8'hA5);
    t_loop(8'd3, 8'h3C);
    t_peer_gate();
    t_txen_overrun();
    t_done_irq();
    t_rx_off();
    t_ext();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule